// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block looks across a small table of 64-bit interrupt list slots and names the slot that should be delivered next. A slot is a candidate only when its two-bit state field says "pending" and nothing else, when its group is enabled, and when it lies inside the part of the table currently in use. Among the candidates, the slot with the numerically lowest 8-bit priority wins. If two candidates have equal priority, the one at the lower slot index wins.

The search is combinational. Its result is captured in output registers on the clock edge at which `start` is high, and the registers keep that result until the next start. When no slot qualifies, the block reports a spurious result and puts the spurious interrupt ID on the value output. A neighbouring block then compares the winner with the priority mask and the running active priority.

Top module: `pri_pick_top`

## Requirements
- R1: The priority of a slot is held in bits 55..48 of the slot. Among candidates, the lowest priority value wins.
- R2: A slot is a candidate only if its state field, bits 63..62, equals 2'b01 (pending). The codes 2'b00 (inactive), 2'b10 (active) and 2'b11 (active and pending) exclude the slot.
- R3: Bit 60 of a slot selects its group. A slot with the bit clear needs `grp0_en` high, and a slot with the bit set needs `grp1_en` high.
- R4: A slot whose priority is 8'hff never wins, even if it is the only pending slot in an enabled group.
- R5: Among candidates of equal priority, the lowest slot index wins.
- R6: Only slots with an index below `used_count` are examined. A count above NUM_SLOTS examines every slot.
- R7: When no slot qualifies, the result is `win_valid`=0, `spurious`=1, `win_idx`=0, and `win_entry` is 1023 in bits 9..0 with all other bits zero.
- R8: The outputs take the result for the inputs present at the rising edge at which `start` is 1. At every other edge they hold their value, whatever the inputs do.
- R9: While `rst_n` is low, `win_valid`=0, `spurious`=0, `win_idx`=0 and `win_entry`=0.
- R10: When `win_valid` is 1, `win_entry` is the complete 64-bit value of the winning slot as it was at the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the search result at this edge |
| entries | input | NUM_SLOTS*64 | Slot table; slot i occupies bits i*64+63..i*64 |
| used_count | input | $clog2(NUM_SLOTS+1) | Number of slots in use |
| grp0_en | input | 1 | Enable for group-0 slots |
| grp1_en | input | 1 | Enable for group-1 slots |
| win_idx | output | max(1,$clog2(NUM_SLOTS)) | Index of the winning slot |
| win_valid | output | 1 | A winner was found |
| win_entry | output | 64 | Winning slot value, or the spurious ID |
| spurious | output | 1 | No slot qualified |

## Verification
Directed patterns isolate one filter at a time:
- Excluded states (inactive, active, active and pending) sit at better priorities than the only pending slot, so a filter that lets any of them through picks the wrong slot.
- Opposite-group pairs are run with each enable turned off in turn, which tells a swapped or ignored enable apart from a correct one.
- Equal-priority slots scattered through the table catch a tie broken towards the wrong index.
- A strong slot placed just past `used_count` catches a bound that is off by one.
- Tables full of 8'hff and tables with every group disabled must both give the spurious result.

Randomized tables mix all state codes, both groups and priorities drawn from a narrow set, so that ties and the 8'hff value come up often. These runs also vary the enables and counts, and change the inputs on cycles without a start to confirm that the outputs hold.

// File: rtl/pri_pick_pkg.sv
package pri_pick_pkg;

   localparam int SLOT_W     = 64;
   localparam int PRI_LSB    = 48;
   localparam int PRI_W      = 8;
   localparam int STATE_LSB  = 62;
   localparam int GROUP_BIT  = 60;
   localparam int SLOT_NUM_W = 8;
   localparam int SPUR_ID    = 1023;

   localparam logic [1:0]       ST_PENDING = 2'b01;
   localparam logic [PRI_W-1:0] IDLE_PRI   = 8'hff;

   typedef struct packed {
      logic                  live;
      logic [PRI_W-1:0]      pri;
      logic [SLOT_NUM_W-1:0] slot;
   } cand_t;

   // lo must come from the lower slot range; equal priority keeps lo
   function automatic cand_t better_of(cand_t lo, cand_t hi);
      if (hi.live && (!lo.live || (hi.pri < lo.pri)))
         return hi;
      return lo;
   endfunction

endpackage

// File: rtl/pri_pick_qualify.sv
module pri_pick_qualify
   import pri_pick_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
   input  logic [NUM_SLOTS*SLOT_W-1:0] entries,
   input  logic [CNT_W-1:0]            used_count,
   input  logic                        grp0_en,
   input  logic                        grp1_en,
   output cand_t [NUM_SLOTS-1:0]       cands
);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      logic [SLOT_W-1:0] word;
      logic [PRI_W-1:0]  pri;
      logic              in_use;
      logic              grp_ok;
      logic              pend_ok;
      logic              beats_idle;

      assign word       = entries[i*SLOT_W +: SLOT_W];
      assign pri        = word[PRI_LSB +: PRI_W];
      assign in_use     = 32'(used_count) > 32'(i);
      assign grp_ok     = word[GROUP_BIT] ? grp1_en : grp0_en;
      assign pend_ok    = word[STATE_LSB +: 2] == ST_PENDING;
      assign beats_idle = pri < IDLE_PRI;

      assign cands[i].live = in_use & grp_ok & pend_ok & beats_idle;
      assign cands[i].pri  = pri;
      assign cands[i].slot = SLOT_NUM_W'(i);
   end

endmodule

// File: rtl/pri_pick_reduce.sv
module pri_pick_reduce
   import pri_pick_pkg::*;
#(
   parameter int NUM_SLOTS   = 16,
   parameter bit TREE_SEARCH = 1'b1
) (
   input  cand_t [NUM_SLOTS-1:0] cands,
   output cand_t                 best
);

   localparam int LEVELS = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 0;
   localparam int PADDED = 1 << LEVELS;
   localparam int NODES  = 2 * PADDED - 1;

   if (TREE_SEARCH) begin : g_tree
      cand_t node [NODES];

      for (genvar i = 0; i < PADDED; i++) begin : g_leaf
         if (i < NUM_SLOTS) begin : g_real
            assign node[PADDED-1+i] = cands[i];
         end else begin : g_pad
            assign node[PADDED-1+i] = '0;
         end
      end

      for (genvar k = 0; k < PADDED - 1; k++) begin : g_node
         assign node[k] = better_of(node[2*k+1], node[2*k+2]);
      end

      assign best = node[0];
   end else begin : g_chain
      always_comb begin
         best = cands[0];
         for (int i = 1; i < NUM_SLOTS; i++)
            best = better_of(best, cands[i]);
      end
   end

endmodule

// File: rtl/pri_pick_hold.sv
module pri_pick_hold
   import pri_pick_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  cand_t                       best,
   input  logic [NUM_SLOTS*SLOT_W-1:0] entries,
   output logic [IDX_W-1:0]            win_idx,
   output logic                        win_valid,
   output logic [SLOT_W-1:0]           win_entry,
   output logic                        spurious
);

   logic [SLOT_W-1:0] slot_val [NUM_SLOTS];
   logic [IDX_W-1:0]  sel;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_unpack
      assign slot_val[i] = entries[i*SLOT_W +: SLOT_W];
   end

   assign sel = best.slot[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_idx   <= '0;
         win_valid <= 1'b0;
         win_entry <= '0;
         spurious  <= 1'b0;
      end else if (load) begin
         if (best.live) begin
            win_idx   <= sel;
            win_valid <= 1'b1;
            win_entry <= slot_val[sel];
            spurious  <= 1'b0;
         end else begin
            win_idx   <= '0;
            win_valid <= 1'b0;
            win_entry <= SLOT_W'(SPUR_ID);
            spurious  <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/pri_pick_top.sv
module pri_pick_top
   import pri_pick_pkg::*;
#(
   parameter int NUM_SLOTS   = 16,
   parameter bit TREE_SEARCH = 1'b1,
   localparam int CNT_W      = $clog2(NUM_SLOTS + 1),
   localparam int IDX_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [NUM_SLOTS*SLOT_W-1:0] entries,
   input  logic [CNT_W-1:0]            used_count,
   input  logic                        grp0_en,
   input  logic                        grp1_en,
   output logic [IDX_W-1:0]            win_idx,
   output logic                        win_valid,
   output logic [SLOT_W-1:0]           win_entry,
   output logic                        spurious
);

   if (NUM_SLOTS < 1 || NUM_SLOTS > (1 << SLOT_NUM_W)) begin : g_bad_slots
      $error("pri_pick_top: NUM_SLOTS out of range");
   end
   if (IDX_W > SLOT_NUM_W) begin : g_bad_idx
      $error("pri_pick_top: index wider than candidate slot field");
   end

   cand_t [NUM_SLOTS-1:0] cands;
   cand_t                 best;

   pri_pick_qualify #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_qualify (
      .entries    (entries),
      .used_count (used_count),
      .grp0_en    (grp0_en),
      .grp1_en    (grp1_en),
      .cands      (cands)
   );

   pri_pick_reduce #(.NUM_SLOTS(NUM_SLOTS), .TREE_SEARCH(TREE_SEARCH)) u_reduce (
      .cands (cands),
      .best  (best)
   );

   pri_pick_hold #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .best      (best),
      .entries   (entries),
      .win_idx   (win_idx),
      .win_valid (win_valid),
      .win_entry (win_entry),
      .spurious  (spurious)
   );

endmodule

// File: rtl/pri_pick_checker.sv
module pri_pick_checker #(
   parameter int CNT_W = 5,
   parameter int IDX_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [CNT_W-1:0]  used_count,
   input logic [IDX_W-1:0]  win_idx,
   input logic              win_valid,
   input logic [63:0]       win_entry,
   input logic              spurious
);

   a_r8_hold_without_start: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(start) |-> ($stable(win_idx) && $stable(win_valid) &&
                         $stable(win_entry) && $stable(spurious)));

   a_r7_spurious_value: assert property (@(posedge clk) disable iff (!rst_n)
      spurious |-> (!win_valid && win_idx == '0 && win_entry == 64'd1023));

   a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start) |-> (win_valid != spurious));

   a_r2_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (win_entry[63:62] == 2'b01));

   a_r4_never_idle: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (win_entry[55:48] != 8'hff));

   a_r6_inside_count: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(start) && win_valid) |-> (32'(win_idx) < 32'($past(used_count))));

endmodule

bind pri_pick_top pri_pick_checker #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .used_count (used_count),
   .win_idx    (win_idx),
   .win_valid  (win_valid),
   .win_entry  (win_entry),
   .spurious   (spurious)
);

// File: tb/pri_pick_top_test.sv
module pri_pick_top_test;

   localparam int N  = 16;
   localparam int CW = 5;
   localparam int IW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [63:0]     ent [N];
   logic [N*64-1:0] flat;
   logic [CW-1:0]   cnt = '0;
   logic            g0 = 1'b0;
   logic            g1 = 1'b0;
   logic [IW-1:0]   win_idx;
   logic            win_valid;
   logic [63:0]     win_entry;
   logic            spurious;

   int    compared = 0;
   int    mismatched = 0;
   bit    done = 1'b0;
   string tag = "R9 reset";

   // model state
   int          m_idx = 0;
   bit          m_valid = 0;
   bit          m_spur = 0;
   logic [63:0] m_entry = '0;

   always #5 clk = ~clk;

   always_comb
      for (int i = 0; i < N; i++) flat[i*64 +: 64] = ent[i];

   pri_pick_top uut (
      .clk(clk), .rst_n(rst_n), .start(start), .entries(flat),
      .used_count(cnt), .grp0_en(g0), .grp1_en(g1),
      .win_idx(win_idx), .win_valid(win_valid), .win_entry(win_entry),
      .spurious(spurious)
   );

   // reference search: walk the table, keep the first strictly better slot
   task automatic model_search();
      int best = -1;
      int bp = 255;
      for (int i = 0; i < N; i++) begin
         bit en;
         if (i >= int'(cnt)) continue;
         if (ent[i][63:62] != 2'b01) continue;
         en = ent[i][60] ? g1 : g0;
         if (!en) continue;
         if (int'(ent[i][55:48]) < bp) begin
            bp = int'(ent[i][55:48]);
            best = i;
         end
      end
      if (best < 0) begin
         m_valid = 0; m_spur = 1; m_idx = 0; m_entry = 64'd1023;
      end else begin
         m_valid = 1; m_spur = 0; m_idx = best; m_entry = ent[best];
      end
   endtask

   always begin
      @(posedge clk);
      if (!rst_n) begin
         m_valid = 0; m_spur = 0; m_idx = 0; m_entry = '0;
      end else if (start) begin
         model_search();
      end
      #2;
      if (!done) begin
         compared++;
         if (win_valid !== m_valid || spurious !== m_spur ||
             int'(win_idx) != m_idx || win_entry !== m_entry) begin
            mismatched++;
            $display("FAIL %s: got valid=%0b spur=%0b idx=%0d entry=%h, expected valid=%0b spur=%0b idx=%0d entry=%h",
                     tag, win_valid, spurious, win_idx, win_entry,
                     m_valid, m_spur, m_idx, m_entry);
         end
      end
   end

   function automatic logic [63:0] mk(logic [1:0] st, bit grp, logic [7:0] pri);
      logic [63:0] w = {$urandom(), $urandom()};
      w[63:62] = st;
      w[60]    = grp;
      w[55:48] = pri;
      return w;
   endfunction

   task automatic clear_table();
      for (int i = 0; i < N; i++) ent[i] = mk(2'b00, 1'b0, 8'h00);
   endtask

   // apply the present table with a start pulse, then one idle cycle
   task automatic fire(string t);
      tag = t;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      clear_table();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: lowest priority value wins
      clear_table(); cnt = 5'd4; g0 = 1; g1 = 1;
      ent[0] = mk(2'b01, 1, 8'd40); ent[1] = mk(2'b01, 1, 8'd20);
      ent[2] = mk(2'b01, 1, 8'd30); ent[3] = mk(2'b01, 1, 8'd50);
      fire("R1 lowest value");

      // R2: excluded state codes at better priorities
      clear_table(); cnt = 5'd16;
      ent[0] = mk(2'b10, 0, 8'd5); ent[1] = mk(2'b11, 0, 8'd6);
      ent[2] = mk(2'b00, 1, 8'd7); ent[3] = mk(2'b01, 1, 8'd9);
      fire("R2 state filter");

      // R3: each enable in turn
      clear_table();
      ent[0] = mk(2'b01, 0, 8'd1); ent[1] = mk(2'b01, 1, 8'd2);
      g0 = 0; g1 = 1; fire("R3 group0 off");
      g0 = 1; g1 = 0; fire("R3 group1 off");
      g0 = 1; g1 = 1; fire("R3 both on");

      // R4: 0xff never wins
      for (int i = 0; i < N; i++) ent[i] = mk(2'b01, i[0], 8'hff);
      fire("R4 all idle priority");
      ent[12] = mk(2'b01, 0, 8'hfe);
      fire("R4 0xfe beats idle");

      // R5: ties to lowest index
      clear_table();
      ent[2] = mk(2'b01, 1, 8'd10); ent[5] = mk(2'b01, 0, 8'd10);
      ent[9] = mk(2'b01, 1, 8'd10); ent[7] = mk(2'b01, 0, 8'd11);
      fire("R5 tie");

      // R6: scan bound
      clear_table();
      ent[5] = mk(2'b01, 1, 8'd1); ent[3] = mk(2'b01, 1, 8'd9);
      cnt = 5'd5; fire("R6 bound excludes 5");
      cnt = 5'd6; fire("R6 bound includes 5");
      cnt = 5'd0; fire("R6 zero count");
      cnt = 5'd31; fire("R6 count above size");

      // R7: nothing enabled
      g0 = 0; g1 = 0; fire("R7 all disabled");

      // R8 and R10: result held while inputs change without start
      g0 = 1; g1 = 1; cnt = 5'd16;
      clear_table(); ent[14] = mk(2'b01, 0, 8'd3);
      fire("R10 full entry value");
      tag = "R8 hold";
      for (int k = 0; k < 4; k++) begin
         ent[14] = mk(2'b01, 0, 8'd200);
         ent[k]  = mk(2'b01, 1, 8'd0);
         g0 = ~g0;
         @(negedge clk);
      end

      // random tables
      for (int it = 0; it < 600; it++) begin
         for (int i = 0; i < N; i++) begin
            logic [7:0] p;
            case ($urandom_range(0, 3))
               0: p = 8'hff;
               1: p = 8'(16 * $urandom_range(0, 3));
               default: p = 8'($urandom_range(0, 255));
            endcase
            ent[i] = mk(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), p);
         end
         g0  = 1'($urandom_range(0, 3) != 0);
         g1  = 1'($urandom_range(0, 3) != 0);
         cnt = 5'($urandom_range(0, 18));
         tag = "R1/R10 random";
         start = 1'b1;
         @(negedge clk);
         start = 1'($urandom_range(0, 1));
         tag = "R8 random hold";
         for (int i = 0; i < N; i++)
            if ($urandom_range(0, 1) != 0) ent[i] = mk(2'b01, 1'b0, 8'd0);
         @(negedge clk);
         start = 1'b0;
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         mismatched++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule